// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives a small accumulator datapath from horizontal microcode. It holds a 256-word by 33-bit microcode store and a register for the current microinstruction. No micro-PC counter exists. Every microword carries the address of the word that follows it. One select bit in the microword can replace that address with an entry from an eight-entry dispatch table, indexed by the 3-bit opcode of the instruction being decoded.

For the branch-on-carry opcode only, the carry flag is forced into the lowest bit of the dispatch address. The taken path and the not-taken path therefore sit in two adjacent microwords.

The register loads on each rising edge, so the whole word stays stable for one cycle. The 24 datapath strobe bits are also presented ANDed with the clock, so they are active only in the high phase. The select bit is presented ungated. An asynchronous reset loads the word at microaddress 0x00, which is the reset microroutine.

Top module: `mseq_top`

## Requirements
- R1: While rst_ni is low, and at once when it falls, uword_o equals the store word at microaddress 0x00.
- R2: The default store word at microaddress a has these fields: [7:0] = (a+1) mod 256, [8] = 1 exactly when a[1:0] = 3, [16:9] = ~a, [24:17] = a XOR 0xA5, [32:25] = a.
- R3: When the current word's bit 8 is 0, the next current word is the store word at the address held in bits [7:0].
- R4: When bit 8 is 1 and the opcode is not 7, the next address is dispatch entry [opcode]. Entry k defaults to 32*k + 16.
- R5: When bit 8 is 1 and the opcode is 7 (branch on carry), the next address is entry 7 with bit 0 replaced by carry_i. This gives 0xF0 for carry 0 and 0xF1 for carry 1.
- R6: uword_o changes only on a rising clock edge. Changes to opcode_i or carry_i within a cycle have no effect on it until the next edge.
- R7: strobe_o equals uword_o[32:9] while clk_i is high and is all zero while clk_i is low.
- R8: map_sel_o equals uword_o[8] in both clock phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; its high phase enables the strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 3 | Opcode field of the instruction register |
| carry_i | input | 1 | Carry flag from the datapath |
| uword_o | output | 33 | Current microinstruction, ungated |
| strobe_o | output | 24 | Datapath control bits gated by the high clock phase |
| map_sel_o | output | 1 | Ungated next-address select bit |

## Verification
The bench walks the microcode through many dispatch points. It uses every opcode with both carry values, so a design that ignored the carry, jammed it for the wrong opcode, or jammed the wrong bit would land on a neighbouring microword. Opcode and carry change in the low phase, and the word is checked again after each change. A design that read the store from live inputs without registering the result would show a new word in the middle of a cycle. Reset is applied in the middle of a high phase to catch a reset that waits for the clock edge. The strobes are checked in both phases, which catches gating on the wrong phase and gating applied to the select bit.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CTRL_W = 24;
  localparam int unsigned WORD_W = CTRL_W + ADDR_W + 1;
  localparam int unsigned NUM_OPC = 8;

  typedef logic [ADDR_W-1:0] map_t [NUM_OPC];

  // default microcode: successor in [7:0], select in [8], control payload above
  function automatic logic [WORD_W-1:0] ucode_word(int unsigned a);
    logic [ADDR_W-1:0] av;
    logic [WORD_W-1:0] w;
    av = a[ADDR_W-1:0];
    w = '0;
    w[7:0]   = av + 8'd1;
    w[8]     = (av[1:0] == 2'b11);
    w[16:9]  = ~av;
    w[24:17] = av ^ 8'hA5;
    w[32:25] = av;
    return w;
  endfunction

  function automatic map_t default_map();
    map_t m;
    for (int k = 0; k < NUM_OPC; k++) m[k] = ADDR_W'(32 * k + 16);
    return m;
  endfunction
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
  parameter int unsigned ADDR_W = mseq_pkg::ADDR_W,
  parameter int unsigned WORD_W = mseq_pkg::WORD_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = WORD_W'(mseq_pkg::ucode_word(i));
  end

  assign rdata_o = rom[raddr_i];
endmodule

// File: rtl/mseq_next.sv
module mseq_next #(
  parameter int unsigned ADDR_W = mseq_pkg::ADDR_W,
  parameter int unsigned OPC_W = 3,
  parameter int unsigned BRC_OPC = 7,
  parameter mseq_pkg::map_t MAP = mseq_pkg::default_map()
) (
  input  logic [ADDR_W-1:0] field_i,
  input  logic              sel_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              carry_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] mapped;

  always_comb begin
    mapped = MAP[opcode_i];
    // carry jammed into bit 0 only for the branch opcode
    if (opcode_i == OPC_W'(BRC_OPC)) mapped[0] = carry_i;
    nxt_o = sel_i ? mapped : field_i;
  end
endmodule

// File: rtl/mseq_gate.sv
module mseq_gate #(
  parameter int unsigned CTRL_W = mseq_pkg::CTRL_W
) (
  input  logic              phase_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] strobe_o
);
  assign strobe_o = ctrl_i & {CTRL_W{phase_i}};
endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
  parameter int unsigned ADDR_W = mseq_pkg::ADDR_W,
  parameter int unsigned CTRL_W = mseq_pkg::CTRL_W,
  parameter int unsigned OPC_W = 3,
  parameter int unsigned BRC_OPC = 7,
  parameter int unsigned RST_ADDR = 0,
  parameter mseq_pkg::map_t MAP = mseq_pkg::default_map(),
  localparam int unsigned WORD_W = CTRL_W + ADDR_W + 1,
  localparam int unsigned SEL_BIT = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              carry_i,
  output logic [WORD_W-1:0] uword_o,
  output logic [CTRL_W-1:0] strobe_o,
  output logic              map_sel_o
);
  logic [ADDR_W-1:0] addr_q, nxt;
  logic [WORD_W-1:0] uword_q, rdata;

  mseq_next #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .BRC_OPC(BRC_OPC), .MAP(MAP)
  ) u_next (
    .field_i (uword_q[ADDR_W-1:0]),
    .sel_i   (uword_q[SEL_BIT]),
    .opcode_i(opcode_i),
    .carry_i (carry_i),
    .nxt_o   (nxt)
  );

  mseq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .raddr_i(nxt),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= ADDR_W'(RST_ADDR);
      uword_q <= WORD_W'(mseq_pkg::ucode_word(RST_ADDR));
    end else begin
      addr_q  <= nxt;
      uword_q <= rdata;
    end
  end

  mseq_gate #(.CTRL_W(CTRL_W)) u_gate (
    .phase_i (clk_i),
    .ctrl_i  (uword_q[WORD_W-1:SEL_BIT+1]),
    .strobe_o(strobe_o)
  );

  assign uword_o   = uword_q;
  assign map_sel_o = uword_q[SEL_BIT];

  AST_SEQ_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uword_q[SEL_BIT] |=> addr_q == $past(uword_q[ADDR_W-1:0])); // R3

  AST_SEQ_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uword_q[SEL_BIT] && opcode_i != OPC_W'(BRC_OPC))
      |=> addr_q == MAP[$past(opcode_i)]); // R4

  AST_BRC_JAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uword_q[SEL_BIT] && opcode_i == OPC_W'(BRC_OPC))
      |=> (addr_q[0] == $past(carry_i)
           && addr_q[ADDR_W-1:1] == MAP[BRC_OPC][ADDR_W-1:1])); // R5

  AST_WORD_TRACKS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> uword_q[WORD_W-1:WORD_W-ADDR_W] == addr_q); // R2
endmodule

// File: tb/mseq_top_bench.sv
module mseq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  opcode = '0;
  logic        carry = 1'b0;
  logic [32:0] uword;
  logic [23:0] strobe;
  logic        map_sel;

  int n_chk = 0;
  int n_fail = 0;
  int ref_addr = 0;
  bit done = 0;

  mseq_top u_mseq_top (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .carry_i(carry),
    .uword_o(uword), .strobe_o(strobe), .map_sel_o(map_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] exp_word(int a);
    logic [7:0] v = a[7:0];
    return {v, v ^ 8'hA5, ~v, (v[1:0] == 2'b11), 8'(v + 8'd1)};
  endfunction

  function automatic int exp_next(int a, int op, bit c);
    logic [32:0] w = exp_word(a);
    int m;
    if (!w[8]) return int'(w[7:0]);
    m = 32 * op + 16;
    if (op == 7) m = (m & 'hFE) | int'(c);
    return m;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h addr=%0d", req, act, expv, ref_addr);
    end
  endtask

  task automatic check_high();
    chk("R2/R3/R4/R5 word", 64'(uword), 64'(exp_word(ref_addr)));
    chk("R7 strobe high", 64'(strobe), 64'(exp_word(ref_addr) >> 9));
    chk("R8 sel high", 64'(map_sel), 64'(exp_word(ref_addr)[8]));
  endtask

  task automatic check_low();
    chk("R6 word stable", 64'(uword), 64'(exp_word(ref_addr)));
    chk("R7 strobe low", 64'(strobe), 64'(0));
    chk("R8 sel low", 64'(map_sel), 64'(exp_word(ref_addr)[8]));
  endtask

  task automatic run(int ncyc, int seed);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk);
      ref_addr = exp_next(ref_addr, int'(opcode), carry);
      #2 check_high();
      #4; // low phase
      opcode = 3'((i + seed) / 3);
      carry  = 1'(((i + seed) / 5) % 2);
      #1 check_low();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    // R1 reset word
    chk("R1 reset word", 64'(uword), 64'(exp_word(0)));
    #(CLK_PERIOD/2);
    rst_n = 1'b1;
    ref_addr = 0;
    run(400, 0);
    // R1 async reset in the middle of a high phase
    @(posedge clk);
    ref_addr = exp_next(ref_addr, int'(opcode), carry);
    #2 rst_n = 1'b0;
    #1;
    ref_addr = 0;
    chk("R1 async reset", 64'(uword), 64'(exp_word(0)));
    chk("R7 strobe in reset", 64'(strobe), 64'(exp_word(0) >> 9));
    @(posedge clk);
    #2 chk("R1 held in reset", 64'(uword), 64'(exp_word(0)));
    #4 rst_n = 1'b1;
    run(300, 7);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule